// File: doc/BRIEF.md
# PWM Fault Trip-Zone Controller

This block guards a pair of PWM outputs against faults. It watches six active-low fault pins and four compare-event strobes. When a fault occurs, it overrides PWM output A and output B with a safe action chosen per output. Each source is routed by its own select bits to one or both of two trip paths.

The cycle-by-cycle path releases itself on a PWM-period pulse once its sources have gone quiet. The one-shot path holds its trip until software clears it. Each path keeps a sticky status flag. The flags feed one combined interrupt flag, which is gated by a per-path enable.

Software configures the block through a small write port. The same port carries clear strobes and force strobes, and a force acts exactly like a real fault. A high-impedance action is presented as a deasserted output-enable. The pad logic is expected to turn that into a tri-state level.

Every fault pin is sampled on each clock edge. A low pulse that spans at least one rising edge is therefore latched. Pulses of three clocks or longer, which is the length the upstream filter guarantees, are always caught.

Top module: `pwm_trip_zone`

## Requirements
- R1: A fault pin counts as a trip source only while it is low and its select bit is set. Fault pin n uses bit n of select register 0 (cycle-by-cycle) and bit n of select register 1 (one-shot). A low pin with both select bits clear changes no output and no flag.
- R2: Compare event 1 (A channel = bit 0, B channel = bit 1) can reach only the one-shot path, through bits 6 and 7 of register 1. Compare event 2 can reach only the cycle-by-cycle path, through bits 6 and 7 of register 0.
- R3: While a cycle-by-cycle source is active, the cycle-by-cycle action is applied to the outputs in the same cycle, with no clock edge in between. With no trip active, each output follows its raw PWM input and its enable is 1.
- R4: The cycle-by-cycle latch clears on a clock edge where period_pulse is high, provided no enabled cycle-by-cycle source and no cycle-by-cycle force is present in that cycle. Otherwise it stays set across period pulses.
- R5: Each path's status flag goes high at the clock edge after its source is seen. It stays high until software clears it: register 4 bit 1 for the cycle-by-cycle flag, bit 2 for the one-shot flag. A clear written while the source is still active leaves the flag at 1.
- R6: The one-shot latch stays set through period pulses. Writing register 4 bit 2 clears both the latch and the one-shot flag, unless a one-shot source is active in that cycle.
- R7: Register 2 holds one 2-bit action per output per path: bits [1:0] one-shot A, [3:2] one-shot B, [5:4] cycle-by-cycle A, [7:6] cycle-by-cycle B. The codes are 00 = high impedance (enable 0), 01 = drive high, 10 = drive low, 11 = pass the PWM input.
- R8: When both paths are active, the one-shot action is applied and the cycle-by-cycle action is ignored.
- R9: Writing register 5 bit 0 (cycle-by-cycle) or bit 1 (one-shot) sets that path's latch and flag at that edge, as a fault would.
- R10: Register 3 bit 0 enables the cycle-by-cycle flag into the interrupt, and bit 1 enables the one-shot flag. trip_irq goes high one edge after an enabled flag is high, which also covers compare event 2 routed through the cycle-by-cycle path. trip_irq is cleared by register 4 bit 0 and sets again while an enabled flag remains high.
- R11: After reset, all select bits and interrupt enables are 0, every action is 11, all latches and flags are 0, and the outputs follow the PWM inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_n | input | NUM_FAULT | Active-low fault pins |
| cmp_evt1 | input | 2 | Compare event 1, bit 0 = A channel, bit 1 = B channel |
| cmp_evt2 | input | 2 | Compare event 2, bit 0 = A channel, bit 1 = B channel |
| period_pulse | input | 1 | One-clock pulse marking the PWM period boundary |
| pwm_a_in | input | 1 | Raw PWM A |
| pwm_b_in | input | 1 | Raw PWM B |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DATA_W | Write data |
| pwm_a_out | output | 1 | Output A level |
| pwm_a_oe | output | 1 | Output A enable, 0 = high impedance |
| pwm_b_out | output | 1 | Output B level |
| pwm_b_oe | output | 1 | Output B enable, 0 = high impedance |
| cbc_flag | output | 1 | Sticky cycle-by-cycle status flag |
| ost_flag | output | 1 | Sticky one-shot status flag |
| trip_irq | output | 1 | Combined trip interrupt flag |

## Verification
Two pairs of functions can collide in one cycle. The first pair is a period pulse and a cycle-by-cycle source that is still active. The second pair is a software clear and a still-present trip, which applies both to a status flag and to the interrupt flag. The bench holds a fault pin low or keeps an enabled flag high across the cycle in which the period pulse or the clear write lands. It then judges that the set wins. The bench also drives both paths at once and checks that the one-shot action, not the cycle-by-cycle one, reaches the output and its enable.

// File: rtl/tz_pkg.sv
package tz_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    ACT_HIZ  = 2'b00,
    ACT_HIGH = 2'b01,
    ACT_LOW  = 2'b10,
    ACT_NONE = 2'b11
  } tz_act_e;

  localparam logic [ADDR_W-1:0] ADDR_SEL_CBC = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_SEL_OST = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_ACTION  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_IRQ_EN  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CLEAR   = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_FORCE   = 3'd5;

  typedef struct packed {
    logic clr_int;
    logic clr_cbc;
    logic clr_ost;
    logic frc_cbc;
    logic frc_ost;
  } tz_strobe_t;
endpackage

// File: rtl/tz_regs.sv
module tz_regs
  import tz_pkg::*;
#(
  parameter int SEL_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SEL_W-1:0]  sel_cbc,
  output logic [SEL_W-1:0]  sel_ost,
  output logic [7:0]        act,
  output logic [1:0]        irq_en,
  output tz_strobe_t        strb
);
  logic [SEL_W-1:0] sel_cbc_q, sel_cbc_d, sel_ost_q, sel_ost_d;
  logic [7:0]       act_q, act_d;
  logic [1:0]       en_q, en_d;

  always_comb begin
    sel_cbc_d = sel_cbc_q;
    sel_ost_d = sel_ost_q;
    act_d     = act_q;
    en_d      = en_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_SEL_CBC: sel_cbc_d = wr_data[SEL_W-1:0];
        ADDR_SEL_OST: sel_ost_d = wr_data[SEL_W-1:0];
        ADDR_ACTION:  act_d     = wr_data[7:0];
        ADDR_IRQ_EN:  en_d      = wr_data[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_cbc_q <= '0;
      sel_ost_q <= '0;
      act_q     <= 8'hFF;
      en_q      <= 2'b00;
    end else if (wr_en) begin
      sel_cbc_q <= sel_cbc_d;
      sel_ost_q <= sel_ost_d;
      act_q     <= act_d;
      en_q      <= en_d;
    end
  end

  logic clr_hit, frc_hit;
  assign clr_hit      = wr_en && (wr_addr == ADDR_CLEAR);
  assign frc_hit      = wr_en && (wr_addr == ADDR_FORCE);
  assign strb.clr_int = clr_hit && wr_data[0];
  assign strb.clr_cbc = clr_hit && wr_data[1];
  assign strb.clr_ost = clr_hit && wr_data[2];
  assign strb.frc_cbc = frc_hit && wr_data[0];
  assign strb.frc_ost = frc_hit && wr_data[1];

  assign sel_cbc = sel_cbc_q;
  assign sel_ost = sel_ost_q;
  assign act     = act_q;
  assign irq_en  = en_q;

  a_r11_action_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && act_q == 8'hFF) |=> (act_q == 8'hFF));
endmodule

// File: rtl/tz_trip_path.sv
module tz_trip_path #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_lvl,
  input  logic [NSRC-1:0] src_sel,
  input  logic            force_set,
  input  logic            latch_clr,
  input  logic            flag_clr,
  output logic            hit,
  output logic            active,
  output logic            flag
);
  logic latch_q, latch_d, flag_q, flag_d, set_now;

  assign hit     = |(src_lvl & src_sel);
  assign set_now = hit || force_set;

  always_comb begin
    latch_d = latch_q;
    flag_d  = flag_q;
    if (set_now) begin
      latch_d = 1'b1;
      flag_d  = 1'b1;
    end else begin
      if (latch_clr) latch_d = 1'b0;
      if (flag_clr)  flag_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      latch_q <= latch_d;
      flag_q  <= flag_d;
    end
  end

  assign active = latch_q || hit;
  assign flag   = flag_q;

  a_r5_flag_follows_source: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
  a_r9_force_sets_both: assert property (@(posedge clk) disable iff (!rst_n)
    force_set |=> (latch_q && flag_q));
  a_r4_release_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_clr && !hit && !force_set) |=> !latch_q);
  a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !latch_clr) |=> latch_q);
endmodule

// File: rtl/tz_out_ctl.sv
module tz_out_ctl
  import tz_pkg::*;
(
  input  logic    pwm_in,
  input  logic    ost_on,
  input  logic    cbc_on,
  input  tz_act_e ost_act,
  input  tz_act_e cbc_act,
  output logic    pin_out,
  output logic    pin_oe
);
  tz_act_e pick;

  always_comb begin
    if (ost_on)      pick = ost_act;
    else if (cbc_on) pick = cbc_act;
    else             pick = ACT_NONE;
  end

  always_comb begin
    case (pick)
      ACT_HIZ:  begin pin_out = 1'b0;   pin_oe = 1'b0; end
      ACT_HIGH: begin pin_out = 1'b1;   pin_oe = 1'b1; end
      ACT_LOW:  begin pin_out = 1'b0;   pin_oe = 1'b1; end
      default:  begin pin_out = pwm_in; pin_oe = 1'b1; end
    endcase
  end
endmodule

// File: rtl/pwm_trip_zone.sv
module pwm_trip_zone
  import tz_pkg::*;
#(
  parameter  int NUM_FAULT = 6,
  localparam int SEL_W     = NUM_FAULT + 2,
  localparam int DATA_W    = (SEL_W > 8) ? SEL_W : 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FAULT-1:0] fault_n,
  input  logic [1:0]           cmp_evt1,
  input  logic [1:0]           cmp_evt2,
  input  logic                 period_pulse,
  input  logic                 pwm_a_in,
  input  logic                 pwm_b_in,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic                 pwm_a_out,
  output logic                 pwm_a_oe,
  output logic                 pwm_b_out,
  output logic                 pwm_b_oe,
  output logic                 cbc_flag,
  output logic                 ost_flag,
  output logic                 trip_irq
);
  localparam int NUM_CH = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic [SEL_W-1:0] sel_cbc, sel_ost;
  logic [7:0]       act_q;
  logic [1:0]       irq_en;
  tz_strobe_t       strb;

  tz_regs #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sel_cbc(sel_cbc), .sel_ost(sel_ost),
    .act(act_q), .irq_en(irq_en), .strb(strb)
  );

  // source vectors: faults in the low bits, compare events above them
  logic [SEL_W-1:0] cbc_lvl, ost_lvl;
  assign cbc_lvl = {cmp_evt2, ~fault_n};
  assign ost_lvl = {cmp_evt1, ~fault_n};

  logic cbc_hit, cbc_active, ost_hit, ost_active;

  tz_trip_path #(.NSRC(SEL_W)) u_cbc (
    .clk(clk), .rst_n(rst_core_n), .src_lvl(cbc_lvl), .src_sel(sel_cbc),
    .force_set(strb.frc_cbc), .latch_clr(period_pulse), .flag_clr(strb.clr_cbc),
    .hit(cbc_hit), .active(cbc_active), .flag(cbc_flag)
  );

  tz_trip_path #(.NSRC(SEL_W)) u_ost (
    .clk(clk), .rst_n(rst_core_n), .src_lvl(ost_lvl), .src_sel(sel_ost),
    .force_set(strb.frc_ost), .latch_clr(strb.clr_ost), .flag_clr(strb.clr_ost),
    .hit(ost_hit), .active(ost_active), .flag(ost_flag)
  );

  logic [NUM_CH-1:0] pwm_in_v, out_v, oe_v;
  assign pwm_in_v = {pwm_b_in, pwm_a_in};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    tz_out_ctl u_out (
      .pwm_in (pwm_in_v[ch]),
      .ost_on (ost_active),
      .cbc_on (cbc_active),
      .ost_act(tz_act_e'(act_q[2*ch+1 : 2*ch])),
      .cbc_act(tz_act_e'(act_q[2*NUM_CH+2*ch+1 : 2*NUM_CH+2*ch])),
      .pin_out(out_v[ch]),
      .pin_oe (oe_v[ch])
    );
  end

  assign pwm_a_out = out_v[0];
  assign pwm_a_oe  = oe_v[0];
  assign pwm_b_out = out_v[1];
  assign pwm_b_oe  = oe_v[1];

  // combined interrupt flag
  logic irq_set, irq_q, irq_d;
  assign irq_set = (irq_en[0] && cbc_flag) || (irq_en[1] && ost_flag);

  always_comb begin
    irq_d = irq_q;
    if (irq_set)           irq_d = 1'b1;
    else if (strb.clr_int) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end
  assign trip_irq = irq_q;

  a_r10_irq_on_flag: assert property (@(posedge clk) disable iff (!rst_core_n)
    (irq_en[0] && cbc_flag) |=> trip_irq);
  a_r10_irq_clears: assert property (@(posedge clk) disable iff (!rst_core_n)
    (strb.clr_int && !irq_set) |=> !trip_irq);
  a_r8_ost_hiz_wins: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ost_active && act_q[1:0] == 2'b00) |-> !pwm_a_oe);
  a_r3_pass_when_idle: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!ost_active && !cbc_active) |-> (pwm_a_out == pwm_a_in && pwm_a_oe && pwm_b_out == pwm_b_in && pwm_b_oe));
endmodule

// File: tb/pwm_trip_zone_tb_top.sv
module pwm_trip_zone_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] fault_n;
  logic [1:0] cmp_evt1, cmp_evt2;
  logic       period_pulse, pwm_a_in, pwm_b_in, wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic       pwm_a_out, pwm_a_oe, pwm_b_out, pwm_b_oe, cbc_flag, ost_flag, trip_irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  pwm_trip_zone dut_i (
    .clk(clk), .rst_n(rst_n), .fault_n(fault_n), .cmp_evt1(cmp_evt1),
    .cmp_evt2(cmp_evt2), .period_pulse(period_pulse), .pwm_a_in(pwm_a_in),
    .pwm_b_in(pwm_b_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_a_out(pwm_a_out), .pwm_a_oe(pwm_a_oe), .pwm_b_out(pwm_b_out),
    .pwm_b_oe(pwm_b_oe), .cbc_flag(cbc_flag), .ost_flag(ost_flag), .trip_irq(trip_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; #1;
  endtask

  task automatic period_tick();
    @(negedge clk); period_pulse = 1'b1;
    @(negedge clk); period_pulse = 1'b0; #1;
  endtask

  task automatic cleanup();
    fault_n = 6'h3F; cmp_evt1 = 2'b00; cmp_evt2 = 2'b00;
    period_tick();
    wr(3'd4, 8'h07);
    wr(3'd4, 8'h01);
  endtask

  task automatic t_reset();
    pwm_a_in = 1'b1; pwm_b_in = 1'b0; #1;
    chk("R11 a_out", pwm_a_out, 1);
    chk("R11 b_out", pwm_b_out, 0);
    chk("R11 oe", {pwm_a_oe, pwm_b_oe}, 2'b11);
    chk("R11 flags", {cbc_flag, ost_flag, trip_irq}, 3'b000);
  endtask

  task automatic t_unselected();
    @(negedge clk); fault_n[2] = 1'b0;
    repeat (3) @(negedge clk); #1;
    chk("R1 unselected out", {pwm_a_out, pwm_b_out}, 2'b10);
    chk("R1 unselected flags", {cbc_flag, ost_flag}, 2'b00);
    fault_n[2] = 1'b1;
  endtask

  task automatic t_cbc();
    wr(3'd0, 8'h04);
    wr(3'd2, 8'b01_10_11_11);
    @(negedge clk); fault_n[2] = 1'b0; #1;
    chk("R3 immediate a", pwm_a_out, 0);
    chk("R3 immediate b", pwm_b_out, 1);
    chk("R5 flag not yet", cbc_flag, 0);
    @(posedge clk); #1;
    chk("R5 flag set", cbc_flag, 1);
    period_tick();
    chk("R4 held while active", pwm_a_out, 0);
    @(negedge clk); fault_n[2] = 1'b1; #1;
    chk("R4 latched after release", {pwm_a_out, pwm_b_out}, 2'b01);
    period_tick();
    chk("R4 released on period", {pwm_a_out, pwm_b_out}, 2'b10);
    @(negedge clk); fault_n[2] = 1'b0;
    wr(3'd4, 8'h02);
    chk("R5 clear while active", cbc_flag, 1);
    @(negedge clk); fault_n[2] = 1'b1;
    wr(3'd4, 8'h02);
    chk("R5 clear when quiet", cbc_flag, 0);
    cleanup();
  endtask

  task automatic t_hiz_force();
    wr(3'd0, 8'h00);
    wr(3'd2, 8'b11_00_11_11);
    wr(3'd5, 8'h01);
    chk("R9 force flag", cbc_flag, 1);
    chk("R7 hiz oe", pwm_a_oe, 0);
    chk("R7 b passes", {pwm_b_out, pwm_b_oe}, 2'b01);
    period_tick();
    chk("R4 force latch released", pwm_a_oe, 1);
    cleanup();
  endtask

  task automatic t_ost();
    pwm_a_in = 1'b0; pwm_b_in = 1'b1;
    wr(3'd0, 8'h00);
    wr(3'd1, 8'hC0);
    wr(3'd2, 8'b11_11_10_01);
    @(negedge clk); cmp_evt2 = 2'b11;
    @(negedge clk); cmp_evt2 = 2'b00; #1;
    chk("R2 evt2 not one-shot", {ost_flag, cbc_flag, pwm_a_out, pwm_b_out}, 4'b0001);
    @(negedge clk); cmp_evt1 = 2'b01;
    @(negedge clk); cmp_evt1 = 2'b00; #1;
    chk("R2 evt1 one-shot flag", ost_flag, 1);
    chk("R7 high/low", {pwm_a_out, pwm_b_out}, 2'b10);
    period_tick();
    period_tick();
    chk("R6 held over periods", {pwm_a_out, pwm_b_out, ost_flag}, 3'b101);
    wr(3'd4, 8'h04);
    chk("R6 cleared", {pwm_a_out, pwm_b_out, ost_flag}, 3'b010);
    cleanup();
  endtask

  task automatic t_priority();
    pwm_a_in = 1'b1;
    wr(3'd0, 8'h01);
    wr(3'd1, 8'h02);
    wr(3'd2, 8'b11_10_11_00);
    @(negedge clk); fault_n[0] = 1'b0; #1;
    chk("R8 cbc only", {pwm_a_out, pwm_a_oe}, 2'b01);
    @(negedge clk); fault_n[1] = 1'b0; #1;
    chk("R8 ost wins", pwm_a_oe, 0);
    @(negedge clk); fault_n = 6'h3F; #1;
    chk("R8 ost latch wins", pwm_a_oe, 0);
    wr(3'd4, 8'h04);
    chk("R8 cbc after ost clear", {pwm_a_out, pwm_a_oe}, 2'b01);
    period_tick();
    chk("R3 pass after release", {pwm_a_out, pwm_a_oe}, 2'b11);
    cleanup();
  endtask

  task automatic t_irq();
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h80);
    wr(3'd3, 8'h01);
    @(negedge clk); cmp_evt2 = 2'b10;
    @(negedge clk); cmp_evt2 = 2'b00; #1;
    chk("R10 flag first", {cbc_flag, trip_irq}, 2'b10);
    @(posedge clk); #1;
    chk("R10 irq via cbc enable", trip_irq, 1);
    wr(3'd4, 8'h01);
    chk("R10 irq re-sets", trip_irq, 1);
    wr(3'd4, 8'h02);
    wr(3'd4, 8'h01);
    chk("R10 irq cleared", trip_irq, 0);
    wr(3'd5, 8'h02);
    repeat (2) @(negedge clk); #1;
    chk("R10 ost disabled", {ost_flag, trip_irq}, 2'b10);
    cleanup();
  endtask

  initial begin
    rst_n = 1'b0; fault_n = 6'h3F; cmp_evt1 = 2'b00; cmp_evt2 = 2'b00;
    period_pulse = 1'b0; pwm_a_in = 1'b1; pwm_b_in = 1'b0;
    wr_en = 1'b0; wr_addr = 3'd0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_unselected();
    t_cbc();
    t_hiz_force();
    t_ost();
    t_priority();
    t_irq();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule